// File: doc/BRIEF.md
# Segmentation Engine Host Sequencer

This block sits between a host and a small image-segmentation engine. The host talks to it over one 8-bit input bus and a select pin. With the select pin high, the byte on the bus is a pixel. With it low, the byte is a command. Pixels go into an image store at ascending addresses. Commands either launch the engine's operator unit or stream the stored image back out.

A single status pin reports progress. It is low while a command is in progress. It is high when the sequencer is idle and any result is ready. The operator's arithmetic and the image store itself sit outside this block. The sequencer reaches them through a start pulse and done input, a registered write port and a read port with one cycle of latency.

Commands are not queued. Anything presented on the bus while the status pin is low is dropped.

Top module: `seg_host_if`

## Requirements
- R1: While reset is held and after release, status_ready is 1, res_valid, op_start and mem_we are 0, and the first accepted pixel is written at address 0.
- R2: While idle with bus_is_pixel high, one pixel is accepted every cycle. It is written through mem_we/mem_waddr/mem_wdata in the following cycle, at an address one higher than the previous pixel.
- R3: Command byte 0x01, taken while idle, produces a one-cycle op_start in the next cycle. status_ready is low from that cycle until the cycle after op_done is seen high.
- R4: op_done pulses that arrive while no operator run is in progress have no effect.
- R5: Command byte 0x02, taken while idle with N>0 pixels stored, streams stored pixels from address 0 upward on res_byte, one per cycle with res_valid high. The first byte appears in the second cycle after the command. status_ready stays low until the cycle after the last byte.
- R6: Command byte 0x02 with no pixels stored does nothing, and status_ready stays high.
- R7: Command byte 0x03, taken while idle, resets the write position so the next pixel goes to address 0. status_ready stays high.
- R8: Command byte 0x00 and every byte from 0x04 to 0xFF taken as a command leave status_ready high, raise no op_start and change no state.
- R9: While status_ready is low, bus bytes are ignored: no pixel is written, and no command runs then or later.
- R10: Once DEPTH pixels are stored, further pixels are dropped without a write strobe. A later readout returns exactly DEPTH bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_in | input | 8 | Shared pixel / command byte |
| bus_is_pixel | input | 1 | High: bus_in is a pixel; low: bus_in is a command |
| status_ready | output | 1 | High when idle or result ready, low while busy |
| res_byte | output | 8 | Streamed result byte |
| res_valid | output | 1 | res_byte holds a valid byte this cycle |
| op_start | output | 1 | One-cycle launch of the operator unit |
| op_done | input | 1 | Operator unit has finished |
| mem_we | output | 1 | Image store write strobe |
| mem_waddr | output | AW | Image store write address |
| mem_wdata | output | 8 | Image store write data |
| mem_re | output | 1 | Image store read request |
| mem_raddr | output | AW | Image store read address |
| mem_rdata | input | 8 | Image store read data, one cycle after mem_re |

## Verification
A wrong write position shows up at the store's write port in the very next accepted pixel. It shows again at readout, where the returned bytes no longer match the order in which they were sent. A sequencer stuck in or leaving a busy state too early changes status_ready within one cycle of the command or of op_done. A wrong read pointer or count makes the stream one byte too long or too short, which shows as a res_valid mismatch in the cycle around the last byte.

// File: rtl/seg_host_pkg.sv
package seg_host_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OPC_NOP  = 8'h00;
  localparam logic [BYTE_W-1:0] OPC_RUN  = 8'h01;
  localparam logic [BYTE_W-1:0] OPC_READ = 8'h02;
  localparam logic [BYTE_W-1:0] OPC_CLR  = 8'h03;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_READ  = 2'd2,
    ST_DRAIN = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic pix_acc;
    logic do_run;
    logic do_read;
    logic do_clr;
  } host_cmd_t;
endpackage

// File: rtl/seg_cmd_decode.sv
module seg_cmd_decode
  import seg_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] bus_in,
  input  logic              bus_is_pixel,
  input  logic              idle,
  input  logic              full,
  input  logic              empty,
  output host_cmd_t         cmd
);
  always_comb begin
    cmd = '0;
    if (idle) begin
      if (bus_is_pixel) begin
        cmd.pix_acc = ~full;
      end else begin
        case (bus_in)
          OPC_NOP:  ;
          OPC_RUN:  cmd.do_run  = 1'b1;
          OPC_READ: cmd.do_read = ~empty;
          OPC_CLR:  cmd.do_clr  = 1'b1;
          default:  ;
        endcase
      end
    end
  end

  assert_cmd_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd.pix_acc, cmd.do_run, cmd.do_read, cmd.do_clr}));

  assert_busy_blocks_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (cmd == '0));
endmodule

// File: rtl/seg_wr_ptr.sv
module seg_wr_ptr
  import seg_host_pkg::*;
#(
  parameter  int unsigned DEPTH = 64,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_acc,
  input  logic              clr,
  input  logic [BYTE_W-1:0] pix_in,
  output logic [CW-1:0]     cnt,
  output logic              full,
  output logic              empty,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [BYTE_W-1:0] mem_wdata
);
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              cnt_en;
  logic              we_q;
  logic [AW-1:0]     waddr_q;
  logic [BYTE_W-1:0] wdata_q;

  assign cnt_en = pix_acc | clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (pix_acc) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b0;
    else        we_q <= pix_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      wdata_q <= '0;
    end else if (pix_acc) begin
      waddr_q <= AW'(cnt_q);
      wdata_q <= pix_in;
    end
  end

  assign cnt       = cnt_q;
  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign mem_we    = we_q;
  assign mem_waddr = waddr_q;
  assign mem_wdata = wdata_q;

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_waddr == $past(mem_waddr) + AW'(1)));

  assert_clear_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

// File: rtl/seg_sequencer.sv
module seg_sequencer
  import seg_host_pkg::*;
#(
  parameter  int unsigned DEPTH = 64,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_run,
  input  logic          do_read,
  input  logic          op_done,
  input  logic [CW-1:0] cnt,
  output logic          idle,
  output logic          op_start,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic          res_valid,
  output logic          status_ready
);
  seq_state_t    state_q, state_d;
  logic [AW-1:0] rd_q, rd_d;
  logic          start_q;
  logic          vld_q;
  logic          last_rd;

  assign last_rd = ({1'b0, rd_q} == (cnt - CW'(1)));

  always_comb begin
    state_d = state_q;
    rd_d    = rd_q;
    case (state_q)
      ST_IDLE: begin
        if (do_run) begin
          state_d = ST_RUN;
        end else if (do_read) begin
          state_d = ST_READ;
          rd_d    = '0;
        end
      end
      ST_RUN:  if (op_done) state_d = ST_IDLE;
      ST_READ: begin
        if (last_rd) state_d = ST_DRAIN;
        else         rd_d    = rd_q + AW'(1);
      end
      ST_DRAIN: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rd_q    <= '0;
      start_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rd_q    <= rd_d;
      start_q <= do_run;
      vld_q   <= (state_q == ST_READ);
    end
  end

  assign idle         = (state_q == ST_IDLE);
  assign status_ready = idle;
  assign op_start     = start_q;
  assign mem_re       = (state_q == ST_READ);
  assign mem_raddr    = rd_q;
  assign res_valid    = vld_q;

  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);

  assert_start_goes_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> !status_ready);

  assert_valid_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !status_ready);

  assert_read_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> ({1'b0, mem_raddr} < cnt));

  assert_release_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_ready) |-> ($past(op_done) || $past(state_q == ST_DRAIN)));
endmodule

// File: rtl/seg_host_if.sv
module seg_host_if
  import seg_host_pkg::*;
#(
  parameter  int unsigned DEPTH = 64,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] bus_in,
  input  logic              bus_is_pixel,
  output logic              status_ready,
  output logic [BYTE_W-1:0] res_byte,
  output logic              res_valid,
  output logic              op_start,
  input  logic              op_done,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_re,
  output logic [AW-1:0]     mem_raddr,
  input  logic [BYTE_W-1:0] mem_rdata
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  host_cmd_t     cmd;
  logic          idle, full, empty;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  seg_cmd_decode u_dec (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .bus_in       (bus_in),
    .bus_is_pixel (bus_is_pixel),
    .idle         (idle),
    .full         (full),
    .empty        (empty),
    .cmd          (cmd)
  );

  seg_wr_ptr #(.DEPTH(DEPTH)) u_wr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pix_acc   (cmd.pix_acc),
    .clr       (cmd.do_clr),
    .pix_in    (bus_in),
    .cnt       (cnt),
    .full      (full),
    .empty     (empty),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata)
  );

  seg_sequencer #(.DEPTH(DEPTH)) u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .do_run       (cmd.do_run),
    .do_read      (cmd.do_read),
    .op_done      (op_done),
    .cnt          (cnt),
    .idle         (idle),
    .op_start     (op_start),
    .mem_re       (mem_re),
    .mem_raddr    (mem_raddr),
    .res_valid    (res_valid),
    .status_ready (status_ready)
  );

  assign res_byte = mem_rdata;
endmodule

// File: tb/seg_host_if_tb.sv
module seg_host_if_tb;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    bus_in;
  logic          bus_is_pixel;
  logic          status_ready;
  logic [7:0]    res_byte;
  logic          res_valid;
  logic          op_start;
  logic          op_done;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;
  logic          mem_re;
  logic [AW-1:0] mem_raddr;
  logic [7:0]    mem_rdata;

  always #2 clk = ~clk;

  seg_host_if #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_is_pixel(bus_is_pixel),
    .status_ready(status_ready), .res_byte(res_byte), .res_valid(res_valid),
    .op_start(op_start), .op_done(op_done), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_re(mem_re),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
  );

  // Image store stand-in
  logic [7:0] store [DEPTH];
  always @(posedge clk) begin
    if (mem_we) store[mem_waddr] <= mem_wdata;
    if (mem_re) mem_rdata <= store[mem_raddr];
  end

  // Behavioural reference model
  int   m_mode;          // 0 idle, 1 run, 2 stream, 3 last byte
  int   m_cnt, m_rd;
  int   m_pix [DEPTH];
  bit   e_we, e_start, e_valid;
  int   e_waddr, e_wdata, e_byte;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_rd = 0;
      e_we = 0; e_start = 0; e_valid = 0; e_waddr = 0; e_wdata = 0; e_byte = 0;
    end else begin
      bit nv;
      e_we = 0; e_start = 0;
      nv = (m_mode == 2);
      if (m_mode == 2) e_byte = m_pix[m_rd];
      case (m_mode)
        0: begin
          if (bus_is_pixel) begin
            if (m_cnt < DEPTH) begin
              e_we = 1; e_waddr = m_cnt; e_wdata = int'(bus_in);
              m_pix[m_cnt] = int'(bus_in); m_cnt++;
            end
          end else begin
            case (bus_in)
              8'h01: begin m_mode = 1; e_start = 1; end
              8'h02: if (m_cnt != 0) begin m_mode = 2; m_rd = 0; end
              8'h03: m_cnt = 0;
              default: ;
            endcase
          end
        end
        1: if (op_done) m_mode = 0;
        2: if (m_rd == m_cnt - 1) m_mode = 3; else m_rd++;
        default: m_mode = 0;
      endcase
      e_valid = nv;
    end
  end

  int    n_chk = 0, n_fail = 0;
  bit    cmp_on = 0;
  bit    done_rep = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(status_ready == (m_mode == 0), cur_req, "status_ready",
          int'(status_ready), int'(m_mode == 0));
      chk(res_valid == e_valid, cur_req, "res_valid", int'(res_valid), int'(e_valid));
      if (e_valid) chk(int'(res_byte) == e_byte, cur_req, "res_byte", int'(res_byte), e_byte);
      chk(op_start == e_start, cur_req, "op_start", int'(op_start), int'(e_start));
      chk(mem_we == e_we, cur_req, "mem_we", int'(mem_we), int'(e_we));
      if (e_we) begin
        chk(int'(mem_waddr) == e_waddr, cur_req, "mem_waddr", int'(mem_waddr), e_waddr);
        chk(int'(mem_wdata) == e_wdata, cur_req, "mem_wdata", int'(mem_wdata), e_wdata);
      end
    end
  end

  task automatic drive(input bit sel, input logic [7:0] b, input bit dn);
    @(negedge clk);
    bus_is_pixel = sel; bus_in = b; op_done = dn;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 8'h00, 1'b0);
  endtask

  task automatic report;
    if (!done_rep) begin
      done_rep = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_in = 8'h00; bus_is_pixel = 1'b0; op_done = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(status_ready == 1'b1, "R1", "status_ready in reset", int'(status_ready), 1);
    chk(res_valid == 1'b0, "R1", "res_valid in reset", int'(res_valid), 0);
    chk(op_start == 1'b0, "R1", "op_start in reset", int'(op_start), 0);
    chk(mem_we == 1'b0, "R1", "mem_we in reset", int'(mem_we), 0);
    rst_n = 1'b1;
    idle_n(4);
    cmp_on = 1;

    // R1 / R2: burst of pixels from address 0
    cur_req = "R2";
    for (int i = 0; i < 5; i++) drive(1'b1, 8'(8'h10 + i * 3), 1'b0);
    idle_n(2);

    // R8: no-op and undefined commands
    cur_req = "R8";
    drive(1'b0, 8'h00, 1'b0);
    drive(1'b0, 8'h04, 1'b0);
    drive(1'b0, 8'h7F, 1'b0);
    drive(1'b0, 8'hFF, 1'b0);
    idle_n(2);

    // R4: stray done in idle
    cur_req = "R4";
    drive(1'b0, 8'h00, 1'b1);
    idle_n(2);

    // R5 with R9: stream while bus is busy with traffic
    cur_req = "R5";
    drive(1'b0, 8'h02, 1'b0);
    cur_req = "R9";
    drive(1'b1, 8'hAA, 1'b0);
    drive(1'b0, 8'h01, 1'b0);
    drive(1'b0, 8'h03, 1'b0);
    cur_req = "R5";
    idle_n(8);

    // R3 with R9: operator run, bus activity ignored
    cur_req = "R3";
    drive(1'b0, 8'h01, 1'b0);
    cur_req = "R9";
    drive(1'b1, 8'h55, 1'b0);
    drive(1'b0, 8'h02, 1'b0);
    drive(1'b0, 8'h01, 1'b0);
    drive(1'b0, 8'h03, 1'b0);
    cur_req = "R3";
    idle_n(3);
    drive(1'b0, 8'h00, 1'b1);
    idle_n(3);

    // R7: clear, then new pixels from 0, stream them
    cur_req = "R7";
    drive(1'b0, 8'h03, 1'b0);
    drive(1'b1, 8'hC1, 1'b0);
    drive(1'b1, 8'hC2, 1'b0);
    drive(1'b1, 8'hC3, 1'b0);
    idle_n(1);
    drive(1'b0, 8'h02, 1'b0);
    idle_n(8);

    // R6: stream request with nothing stored
    cur_req = "R6";
    drive(1'b0, 8'h03, 1'b0);
    drive(1'b0, 8'h02, 1'b0);
    idle_n(3);

    // R10: overfill and stream the full image
    cur_req = "R10";
    for (int i = 0; i < DEPTH + 3; i++) drive(1'b1, 8'(i * 7 + 3), 1'b0);
    idle_n(1);
    drive(1'b0, 8'h02, 1'b0);
    idle_n(DEPTH + 6);

    cmp_on = 0;
    report();
    $finish;
  end
endmodule